// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns a port of 32 already-synchronized pin inputs into one interrupt line. Each pin has its own control word on a simple register bus. A 4-bit mode field in that word selects what the pin watches for: nothing, a low level, a high level, a rising edge, a falling edge, or either edge. When the selected condition occurs, the pin's bit in a shared status-flag register is set.

Software reads the status register to find out which pins fired. It clears a flag by writing a 1 to that bit. The interrupt output is a registered OR of all flags, so it stays asserted while any pin still has a flag set.

Edges are found by comparing each pin's current value with its value in the previous cycle. Level modes set the flag again on every cycle that the level is present. If a detected event and a clear reach the same bit in the same cycle, the event takes priority.

Top module: `pirq_detector`

## Requirements
- R1: After reset, every status flag is 0, `irq_out` is 0 and every control word reads back as 0.
- R2: The control word for pin n is at byte address 4*n (n = 0..31). The mode field is bits [19:16]. Writes store only that field, and all other bits read back as 0.
- R3: Mode code 0x9 sets the pin's flag in the cycle after the pin goes from 0 to 1. A falling transition or a steady level does not set it.
- R4: Mode code 0xA sets the flag after a 1-to-0 transition of the pin. A rising transition does not set it.
- R5: Mode code 0xB sets the flag after a transition in either direction.
- R6: Mode codes 0x8 (pin low) and 0xC (pin high) set the flag on every cycle that the level is present, so a clear written while the level persists leaves the flag set.
- R7: Mode code 0x0 and every code not listed in R3 to R6 disable detection for the pin.
- R8: The status register is at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and writing all ones clears every flag.
- R9: When an event and a clear hit the same flag in the same cycle, the flag stays set.
- R10: `irq_out` is the OR of all status flags, delayed by one register stage.
- R11: Writing 0 to a pin's control word stops new flags for that pin, and a flag already set stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Byte address for register reads and writes |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Synchronized pin levels |
| irq_out | output | 1 | Aggregated interrupt, registered |

## Verification
The hardest case to reach from the ports is a clear and a fresh edge landing on the same flag in the same clock cycle. The bench reaches it by arming an either-edge pin, taking a first edge to set the flag, and then, on one falling clock edge, toggling the pin and issuing the write-one-to-clear together. The flag must still read set afterwards. The level-mode cases are handled the same way: the clear is issued while the level is held, and again after the level is removed, and the two outcomes are told apart.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 4'h0,
    MODE_LVL_LO = 4'h8,
    MODE_RISE   = 4'h9,
    MODE_FALL   = 4'hA,
    MODE_BOTH   = 4'hB,
    MODE_LVL_HI = 4'hC
  } pirq_mode_e;

  // Condition evaluation for one pin; unlisted codes yield no event.
  function automatic logic pirq_hit(logic [MODE_W-1:0] mode, logic cur, logic prev);
    logic hit;
    hit = 1'b0;
    case (mode)
      MODE_LVL_LO: hit = ~cur;
      MODE_RISE:   hit = cur & ~prev;
      MODE_FALL:   hit = ~cur & prev;
      MODE_BOTH:   hit = cur ^ prev;
      MODE_LVL_HI: hit = cur;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pirq_rst_sync.sv
module pirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [MODE_W-1:0]                mode_wdata_i,
  output logic [NUM_PINS-1:0][MODE_W-1:0]  mode_o
);

  logic [NUM_PINS-1:0][MODE_W-1:0] mode_d;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_q;
  logic [NUM_PINS-1:0]             mode_en;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(4 * gi);

    always_comb begin
      mode_en[gi] = wr_i && (addr_i == PIN_ADDR);
      mode_d[gi]  = mode_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[gi] <= '0;
      end else if (mode_en[gi]) begin
        mode_q[gi] <= mode_d[gi];
      end
    end

    // R11
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == PIN_ADDR && mode_wdata_i == '0) |=> (mode_o[gi] == '0));

    // R2
    other_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i || addr_i != PIN_ADDR) |=> $stable(mode_o[gi]));
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/pirq_event_detect.sv
module pirq_event_detect
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PINS-1:0]              pin_i,
  input  logic [NUM_PINS-1:0][MODE_W-1:0]  mode_i,
  output logic [NUM_PINS-1:0]              evt_o
);

  logic [NUM_PINS-1:0] prev_d;
  logic [NUM_PINS-1:0] prev_q;
  logic                prev_en;

  always_comb begin
    prev_en = 1'b1;
    prev_d  = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    always_comb begin
      evt_o[gi] = pirq_hit(mode_i[gi], pin_i[gi], prev_q[gi]);
    end

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[gi] == MODE_OFF) |-> !evt_o[gi]);

    // R6
    lvl_hi_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[gi] == MODE_LVL_HI && pin_i[gi]) |-> evt_o[gi]);

    // R6
    lvl_lo_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[gi] == MODE_LVL_LO && !pin_i[gi]) |-> evt_o[gi]);

    // R3
    rise_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[gi] == MODE_RISE && $stable(pin_i[gi]) && $stable(prev_q[gi])
       && prev_q[gi] == pin_i[gi]) |-> !evt_o[gi]);
  end

endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flag_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] flag_d;
  logic [NUM_PINS-1:0] flag_q;
  logic                flag_en;
  logic                irq_d;
  logic                irq_q;

  always_comb begin
    flag_en = (|clr_i) || (|evt_i);
    flag_d  = (flag_q & ~clr_i) | evt_i;
    irq_d   = |flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_bit
    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[gi] |=> flag_q[gi]);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[gi] && !evt_i[gi]) |=> !flag_q[gi]);

    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[gi] && !evt_i[gi]) |=> !flag_q[gi]);
  end

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |=> !irq_q);

  // R10
  irq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |=> irq_q);

endmodule

// File: rtl/pirq_detector.sv
module pirq_detector
  import pirq_pkg::*;
#(
  parameter int                NUM_PINS  = 32,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                MODE_LSB  = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                irq_out
);

  localparam int                PIN_IDX_W  = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] CTRL_LIMIT = ADDR_W'(4 * NUM_PINS);

  logic                            rst_sync_n;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_bus;
  logic [NUM_PINS-1:0]             evt_bus;
  logic [NUM_PINS-1:0]             clr_bus;
  logic [NUM_PINS-1:0]             flag_bus;
  logic [PIN_IDX_W-1:0]            rd_idx;
  logic                            rd_ctrl_hit;

  pirq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pirq_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_i         (reg_wr),
    .addr_i       (reg_addr),
    .mode_wdata_i (reg_wdata[MODE_LSB +: MODE_W]),
    .mode_o       (mode_bus)
  );

  pirq_event_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (pin_in),
    .mode_i (mode_bus),
    .evt_o  (evt_bus)
  );

  always_comb begin
    clr_bus = '0;
    if (reg_wr && reg_addr == FLAG_ADDR) begin
      clr_bus = reg_wdata[NUM_PINS-1:0];
    end
  end

  pirq_flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt_bus),
    .clr_i  (clr_bus),
    .flag_o (flag_bus),
    .irq_o  (irq_out)
  );

  always_comb begin
    rd_idx      = reg_addr[2 +: PIN_IDX_W];
    rd_ctrl_hit = (reg_addr[1:0] == 2'b00) && (reg_addr < CTRL_LIMIT);
    reg_rdata   = '0;
    if (reg_addr == FLAG_ADDR) begin
      reg_rdata[NUM_PINS-1:0] = flag_bus;
    end else if (rd_ctrl_hit) begin
      reg_rdata[MODE_LSB +: MODE_W] = mode_bus[rd_idx];
    end
  end

endmodule

// File: tb/pirq_detector_tb.sv
`timescale 1ns/1ps
module pirq_detector_tb_top;

  localparam logic [7:0] FLAG_A = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pirq_detector dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .irq_out   (irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Called on a falling edge; returns on the falling edge after the write lands.
  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    pin_in    = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apply_reset();
    rd_reg(FLAG_A, d);       chk("R1 flags", d, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    rd_reg(8'h00, d);        chk("R1 ctrl0", d, 32'h0);
    rd_reg(8'h7C, d);        chk("R1 ctrl31", d, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    rd_reg(8'h1C, d);        chk("R2 field only", d, 32'h000F_0000);
    wr_reg(8'h7C, 32'h0009_0000);
    rd_reg(8'h7C, d);        chk("R2 pin31", d, 32'h0009_0000);
    rd_reg(8'h18, d);        chk("R2 neighbour", d, 32'h0);
    rd_reg(8'h1E, d);        chk("R2 unaligned", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h0C, 32'h0009_0000);
    step(2);
    rd_reg(FLAG_A, d);       chk("R3 idle", d, 32'h0);
    pin_in[3] = 1'b1;
    step(1);
    rd_reg(FLAG_A, d);       chk("R3 rise sets", d, 32'h8);
    wr_reg(FLAG_A, 32'h8);
    step(2);
    rd_reg(FLAG_A, d);       chk("R3 held high no reset", d, 32'h0);
    pin_in[3] = 1'b0;
    step(2);
    rd_reg(FLAG_A, d);       chk("R3 fall ignored", d, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h10, 32'h000A_0000);
    pin_in[4] = 1'b1;
    step(2);
    rd_reg(FLAG_A, d);       chk("R4 rise ignored", d, 32'h0);
    pin_in[4] = 1'b0;
    step(1);
    rd_reg(FLAG_A, d);       chk("R4 fall sets", d, 32'h10);
  endtask

  task automatic t_both();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h18, 32'h000B_0000);
    pin_in[6] = 1'b1;
    step(1);
    rd_reg(FLAG_A, d);       chk("R5 rise", d, 32'h40);
    wr_reg(FLAG_A, 32'h40);
    rd_reg(FLAG_A, d);       chk("R5 cleared", d, 32'h0);
    pin_in[6] = 1'b0;
    step(1);
    rd_reg(FLAG_A, d);       chk("R5 fall", d, 32'h40);
  endtask

  task automatic t_level();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h28, 32'h000C_0000);
    step(2);
    rd_reg(FLAG_A, d);       chk("R6 high idle", d, 32'h0);
    pin_in[10] = 1'b1;
    step(1);
    rd_reg(FLAG_A, d);       chk("R6 high sets", d, 32'h400);
    wr_reg(FLAG_A, 32'h400);
    rd_reg(FLAG_A, d);       chk("R6 clear while high", d, 32'h400);
    pin_in[10] = 1'b0;
    step(1);
    wr_reg(FLAG_A, 32'h400);
    rd_reg(FLAG_A, d);       chk("R6 clear after drop", d, 32'h0);
    wr_reg(8'h2C, 32'h0008_0000);
    step(1);
    rd_reg(FLAG_A, d);       chk("R6 low sets", d, 32'h800);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h08, 32'h0005_0000);
    wr_reg(8'h3C, 32'h000F_0000);
    pin_in[2]  = 1'b1;
    pin_in[1]  = 1'b1;
    pin_in[15] = 1'b1;
    step(2);
    pin_in[2]  = 1'b0;
    pin_in[1]  = 1'b0;
    step(2);
    rd_reg(FLAG_A, d);       chk("R7 off and unused", d, 32'h0);
    chk("R7 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h0C, 32'h0009_0000);
    wr_reg(8'h20, 32'h0009_0000);
    pin_in[3] = 1'b1;
    pin_in[8] = 1'b1;
    step(1);
    rd_reg(FLAG_A, d);       chk("R8 two flags", d, 32'h108);
    wr_reg(FLAG_A, 32'h0);
    rd_reg(FLAG_A, d);       chk("R8 zero write", d, 32'h108);
    wr_reg(FLAG_A, 32'h8);
    rd_reg(FLAG_A, d);       chk("R8 single clear", d, 32'h100);
    wr_reg(FLAG_A, 32'hFFFF_FFFF);
    rd_reg(FLAG_A, d);       chk("R8 all ones", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h14, 32'h000B_0000);
    pin_in[5] = 1'b1;
    step(1);
    rd_reg(FLAG_A, d);       chk("R9 armed", d, 32'h20);
    pin_in[5] = 1'b0;
    wr_reg(FLAG_A, 32'h20);
    rd_reg(FLAG_A, d);       chk("R9 event wins", d, 32'h20);
    wr_reg(FLAG_A, 32'h20);
    rd_reg(FLAG_A, d);       chk("R9 later clear", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h00, 32'h0009_0000);
    pin_in[0] = 1'b1;
    step(1);
    rd_reg(FLAG_A, d);       chk("R10 flag", d, 32'h1);
    chk("R10 irq lag", {31'b0, irq_out}, 32'h0);
    step(1);
    chk("R10 irq up", {31'b0, irq_out}, 32'h1);
    wr_reg(FLAG_A, 32'h1);
    chk("R10 irq hold", {31'b0, irq_out}, 32'h1);
    step(1);
    chk("R10 irq down", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    apply_reset();
    wr_reg(8'h50, 32'h0009_0000);
    pin_in[20] = 1'b1;
    step(1);
    wr_reg(8'h50, 32'h0);
    rd_reg(FLAG_A, d);       chk("R11 flag kept", d, 32'h0010_0000);
    wr_reg(FLAG_A, 32'h0010_0000);
    pin_in[20] = 1'b0;
    step(2);
    pin_in[20] = 1'b1;
    step(2);
    rd_reg(FLAG_A, d);       chk("R11 masked", d, 32'h0);
    chk("R11 irq", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    pin_in    = '0;
    t_reset();
    t_ctrl_rw();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_disabled();
    t_w1c();
    t_collide();
    t_irq();
    t_mask();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule